// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several operating modes. A 5-bit mode code, captured by a load strobe, selects which bank of physical storage answers for the registers that are shadowed per mode. Two combinational read ports and one write port always work on the current mode. A separate debug port reads or writes any register as a chosen mode sees it. The program counter is not stored here: register 15 reads return an externally supplied value.

Shadowing is irregular. The fast-interrupt bank owns its own r8 to r14. The interrupt, supervisor, abort and undefined banks own only r13 and r14 and share r8 to r12 with user mode. System mode uses the user registers throughout. Any mode code without a defined meaning selects a dummy bank whose r8 to r14 are zeroed whenever the core enters or leaves it. Five banks also keep a saved status word, written under four byte enables, and a lookup of a bank without one returns the current status word supplied at a port.

All ports are plain control and data pins without a handshake: every access completes in the cycle it is presented, so there is no back-pressure.

Top module: `mbank_regfile`

## Requirements
- R1: Mode codes map to banks: 0 and 16 user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined, 31 system; every other 5-bit code maps to the dummy bank.
- R2: The fast-interrupt bank has private r8 to r14; interrupt, supervisor, abort and undefined banks have private r13 and r14 and use the user r8 to r12; system mode uses the user r8 to r14.
- R3: The user r8 to r12 keep their values across a stay in the fast-interrupt bank or the dummy bank and read back unchanged on return.
- R4: On any mode load that enters or leaves the dummy bank, the dummy r8 to r14 become zero; values written while in the dummy bank are lost on leaving it.
- R5: A debug access naming mode M reaches the physical register that bank(M) sees; naming the current mode reaches the same registers the read and write ports use.
- R6: A mode load between two codes of the same bank changes no register.
- R7: Saved status exists only for fast-interrupt, interrupt, supervisor, abort and undefined; a write naming another bank is ignored, and a read naming another bank returns `cur_psr`.
- R8: Saved status byte enable bit 0 writes bits 7:0 (control), bit 1 bits 15:8 (extension), bit 2 bits 23:16 (status), bit 3 bits 31:24 (flags); unselected bytes keep their value.
- R9: r0 to r7 are one physical set for all modes; reading r15 on any port returns `pc_in`, and a write to r15 changes nothing.
- R10: A register write in the same cycle as a mode load lands in the bank of the old mode; a port write and a debug write to the same physical register in one cycle leave the port write's value.
- R11: Synchronous active-low reset sets the mode to 19 (supervisor) and clears every saved status word and every general register.
- R12: Reads are combinational from current state; a write or a mode load takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_in | input | 5 | Mode code to load |
| mode_load | input | 1 | Load strobe for mode_in |
| mode_o | output | 5 | Current mode code |
| pc_in | input | 32 | Value returned for r15 |
| rda_addr | input | 4 | Read port A register number |
| rda_data | output | 32 | Read port A data |
| rdb_addr | input | 4 | Read port B register number |
| rdb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 4 | Write port register number |
| wr_data | input | 32 | Write port data |
| dbg_mode | input | 5 | Mode whose view the debug port uses |
| dbg_addr | input | 4 | Debug register number |
| dbg_wr_en | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| cur_psr | input | 32 | Current status word, returned for banks without saved status |
| sps_mode | input | 5 | Mode whose saved status is accessed |
| sps_wr_en | input | 1 | Saved status write enable |
| sps_byte_en | input | 4 | Saved status byte enables |
| sps_wdata | input | 32 | Saved status write data |
| sps_rdata | output | 32 | Saved status read data |

## Verification
The same-bank switch assertion only speaks for cycles in which neither write port is active, so it takes for granted that callers may combine a switch with a write and checks those cycles through the bench instead. The dummy-clear and r15-ignore assertions assume the reset is held across at least one rising edge before any check matters. The stimulus changes every input just after a falling edge, holds reset low for two edges at start and once more mid-run, and issues combined switch-plus-write cycles only in the directed part where the expected bank is computed by hand.

// File: rtl/mbrf_pkg.sv
package mbrf_pkg;

  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS, BK_DMY
  } bank_e;

  localparam int MODE_W   = 5;
  localparam int ADDR_W   = 4;
  localparam int HI_CNT   = 7;                     // r8..r14
  localparam int PRV_CNT  = 4;                     // banks owning r13/r14 only
  localparam int USR_BASE = 8;
  localparam int FIQ_BASE = USR_BASE + HI_CNT;
  localparam int DMY_BASE = FIQ_BASE + HI_CNT;
  localparam int PRV_BASE = DMY_BASE + HI_CNT;
  localparam int NUM_SLOT = PRV_BASE + 2 * PRV_CNT;
  localparam int SLOT_W   = $clog2(NUM_SLOT + 1);
  localparam logic [SLOT_W-1:0] SLOT_NONE = '1;
  localparam int NUM_SPS  = 5;
  localparam int SPS_IW   = $clog2(NUM_SPS);

  function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
    case (m)
      5'd0,  5'd16: return BK_USR;
      5'd1,  5'd17: return BK_FIQ;
      5'd2,  5'd18: return BK_IRQ;
      5'd3,  5'd19: return BK_SVC;
      5'd23:        return BK_ABT;
      5'd27:        return BK_UND;
      5'd31:        return BK_SYS;
      default:      return BK_DMY;
    endcase
  endfunction

  function automatic logic has_sps(input bank_e b);
    return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
           (b == BK_ABT) || (b == BK_UND);
  endfunction

  function automatic logic [SPS_IW-1:0] sps_index(input bank_e b);
    return SPS_IW'(int'(b) - 1);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input bank_e b, input logic [ADDR_W-1:0] a);
    logic [SLOT_W-1:0] off;
    off = SLOT_W'(a[2:0]);
    if (a == 4'd15) return SLOT_NONE;
    if (!a[3]) return SLOT_W'(a);
    if (b == BK_FIQ) return SLOT_W'(FIQ_BASE) + off;
    if (b == BK_DMY) return SLOT_W'(DMY_BASE) + off;
    if ((b == BK_IRQ || b == BK_SVC || b == BK_ABT || b == BK_UND) && a >= 4'd13)
      return SLOT_W'(PRV_BASE) + SLOT_W'(2 * (int'(b) - int'(BK_IRQ))) + SLOT_W'(a == 4'd14);
    return SLOT_W'(USR_BASE) + off;
  endfunction

endpackage

// File: rtl/mbrf_mode_ctl.sv
module mbrf_mode_ctl
  import mbrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_in,
  input  logic              mode_load,
  output logic [MODE_W-1:0] mode_q,
  output bank_e             cur_bank,
  output bank_e             next_bank,
  output logic              clr_dummy
);
  localparam logic [MODE_W-1:0] RESET_MODE = 5'd19;

  always_ff @(posedge clk) begin
    if (!rst_n)         mode_q <= RESET_MODE;
    else if (mode_load) mode_q <= mode_in;
  end

  always_comb begin
    cur_bank  = mode_to_bank(mode_q);
    next_bank = mode_to_bank(mode_in);
    clr_dummy = mode_load && (next_bank != cur_bank) &&
                (next_bank == BK_DMY || cur_bank == BK_DMY);
  end

  assert_mode_switch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> mode_q == $past(mode_in));

  assert_no_load_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(mode_q));

endmodule

// File: rtl/mbrf_bank_store.sv
module mbrf_bank_store
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             cur_bank,
  input  bank_e             next_bank,
  input  logic              mode_load,
  input  logic              clr_dummy,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] rda_addr,
  output logic [DATA_W-1:0] rda_data,
  input  logic [ADDR_W-1:0] rdb_addr,
  output logic [DATA_W-1:0] rdb_data,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  bank_e             dbg_bank,
  input  logic [ADDR_W-1:0] dbg_addr,
  input  logic              dbg_we,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata
);
  logic [NUM_SLOT-1:0][DATA_W-1:0] phys;
  logic [SLOT_W-1:0] core_slot, dbg_slot;

  assign core_slot = slot_of(cur_bank, core_addr);
  assign dbg_slot  = slot_of(dbg_bank, dbg_addr);

  function automatic logic [DATA_W-1:0] pick(input logic [SLOT_W-1:0] s,
                                             input logic [NUM_SLOT-1:0][DATA_W-1:0] st,
                                             input logic [DATA_W-1:0] pc);
    if (s == SLOT_NONE) return pc;
    return st[s];
  endfunction

  always_comb begin
    rda_data  = pick(slot_of(cur_bank, rda_addr), phys, pc_in);
    rdb_data  = pick(slot_of(cur_bank, rdb_addr), phys, pc_in);
    dbg_rdata = pick(dbg_slot, phys, pc_in);
  end

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    localparam bit IS_DMY = (i >= DMY_BASE) && (i < DMY_BASE + HI_CNT);
    always_ff @(posedge clk) begin
      if (!rst_n)
        phys[i] <= '0;
      else if (IS_DMY && clr_dummy)
        phys[i] <= '0;
      else if (core_we && core_slot == SLOT_W'(i))
        phys[i] <= core_wdata;
      else if (dbg_we && dbg_slot == SLOT_W'(i))
        phys[i] <= dbg_wdata;
    end
  end

  assert_dummy_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_dummy |=> phys[DMY_BASE +: HI_CNT] == '0);

  assert_pc_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && core_addr == 4'd15 && !dbg_we && !clr_dummy) |=> $stable(phys));

  assert_same_bank_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_load && next_bank == cur_bank && !core_we && !dbg_we) |=> $stable(phys));

endmodule

// File: rtl/mbrf_saved_status.sv
module mbrf_saved_status
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             sel_bank,
  input  logic              we,
  input  logic [NB-1:0]     be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cur_psr,
  output logic [DATA_W-1:0] rdata
);
  logic [NUM_SPS-1:0][DATA_W-1:0] sps_q;
  logic              sel_ok;
  logic [SPS_IW-1:0] sel_idx;

  assign sel_ok  = has_sps(sel_bank);
  assign sel_idx = sps_index(sel_bank);
  assign rdata   = sel_ok ? sps_q[sel_idx] : cur_psr;

  for (genvar i = 0; i < NUM_SPS; i++) begin : g_word
    for (genvar j = 0; j < NB; j++) begin : g_byte
      always_ff @(posedge clk) begin
        if (!rst_n)
          sps_q[i][8*j +: 8] <= '0;
        else if (we && sel_ok && sel_idx == SPS_IW'(i) && be[j])
          sps_q[i][8*j +: 8] <= wdata[8*j +: 8];
      end

      assert_byte_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel_idx == SPS_IW'(i) && !be[j]) |=> $stable(sps_q[i][8*j +: 8]));
    end
  end

  assert_no_sps_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !sel_ok) |=> $stable(sps_q));

endmodule

// File: rtl/mbank_regfile.sv
module mbank_regfile
  import mbrf_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_in,
  input  logic              mode_load,
  output logic [4:0]        mode_o,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [3:0]        rda_addr,
  output logic [DATA_W-1:0] rda_data,
  input  logic [3:0]        rdb_addr,
  output logic [DATA_W-1:0] rdb_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [4:0]        dbg_mode,
  input  logic [3:0]        dbg_addr,
  input  logic              dbg_wr_en,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  input  logic [DATA_W-1:0] cur_psr,
  input  logic [4:0]        sps_mode,
  input  logic              sps_wr_en,
  input  logic [NB-1:0]     sps_byte_en,
  input  logic [DATA_W-1:0] sps_wdata,
  output logic [DATA_W-1:0] sps_rdata
);
  bank_e cur_bank, next_bank;
  logic  clr_dummy;

  mbrf_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_in   (mode_in),
    .mode_load (mode_load),
    .mode_q    (mode_o),
    .cur_bank  (cur_bank),
    .next_bank (next_bank),
    .clr_dummy (clr_dummy)
  );

  mbrf_bank_store #(.DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur_bank   (cur_bank),
    .next_bank  (next_bank),
    .mode_load  (mode_load),
    .clr_dummy  (clr_dummy),
    .pc_in      (pc_in),
    .rda_addr   (rda_addr),
    .rda_data   (rda_data),
    .rdb_addr   (rdb_addr),
    .rdb_data   (rdb_data),
    .core_we    (wr_en),
    .core_addr  (wr_addr),
    .core_wdata (wr_data),
    .dbg_bank   (mode_to_bank(dbg_mode)),
    .dbg_addr   (dbg_addr),
    .dbg_we     (dbg_wr_en),
    .dbg_wdata  (dbg_wdata),
    .dbg_rdata  (dbg_rdata)
  );

  mbrf_saved_status #(.DATA_W(DATA_W)) u_sps (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_bank (mode_to_bank(sps_mode)),
    .we       (sps_wr_en),
    .be       (sps_byte_en),
    .wdata    (sps_wdata),
    .cur_psr  (cur_psr),
    .rdata    (sps_rdata)
  );

endmodule

// File: tb/tb_mbank_regfile.sv
module tb_mbank_regfile;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n;
  logic [4:0]  mode_in, dbg_mode, sps_mode, mode_o;
  logic        mode_load, wr_en, dbg_wr_en, sps_wr_en;
  logic [3:0]  rda_addr, rdb_addr, wr_addr, dbg_addr, sps_byte_en;
  logic [31:0] pc_in, wr_data, dbg_wdata, cur_psr, sps_wdata;
  logic [31:0] rda_data, rdb_data, dbg_rdata, sps_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbank_regfile dut (.*);

  typedef struct packed {
    logic        ld;
    logic [4:0]  md;
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic [3:0]  ra;
    logic [31:0] ex;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 5'd16, 1'b0, 4'd0,  32'h0,   4'd0,  32'h0},   // R11 reset value, user
    '{1'b0, 5'd0,  1'b1, 4'd8,  32'hA8,  4'd8,  32'hA8},  // R12
    '{1'b0, 5'd0,  1'b1, 4'd13, 32'h13,  4'd13, 32'h13},
    '{1'b0, 5'd0,  1'b1, 4'd0,  32'h100, 4'd0,  32'h100},
    '{1'b1, 5'd17, 1'b0, 4'd0,  32'h0,   4'd8,  32'h0},   // R2 fiq r8 private
    '{1'b0, 5'd0,  1'b1, 4'd8,  32'hF8,  4'd8,  32'hF8},
    '{1'b0, 5'd0,  1'b1, 4'd13, 32'hF13, 4'd13, 32'hF13},
    '{1'b1, 5'd18, 1'b0, 4'd0,  32'h0,   4'd8,  32'hA8},  // R3 user r8 back
    '{1'b0, 5'd0,  1'b0, 4'd0,  32'h0,   4'd13, 32'h0},   // R2 irq r13 private
    '{1'b0, 5'd0,  1'b1, 4'd13, 32'h1D,  4'd13, 32'h1D},
    '{1'b1, 5'd2,  1'b1, 4'd14, 32'hE2,  4'd13, 32'h1D},  // R6 same bank
    '{1'b0, 5'd0,  1'b0, 4'd0,  32'h0,   4'd14, 32'hE2},
    '{1'b1, 5'd31, 1'b0, 4'd0,  32'h0,   4'd13, 32'h13},  // R2 system = user
    '{1'b1, 5'd5,  1'b0, 4'd0,  32'h0,   4'd8,  32'h0},   // R4 dummy reads zero
    '{1'b0, 5'd0,  1'b1, 4'd9,  32'h99,  4'd9,  32'h99},
    '{1'b1, 5'd16, 1'b1, 4'd10, 32'hAA,  4'd8,  32'hA8},  // R3 after dummy
    '{1'b1, 5'd5,  1'b0, 4'd0,  32'h0,   4'd9,  32'h0},   // R4 discarded
    '{1'b1, 5'd19, 1'b0, 4'd0,  32'h0,   4'd0,  32'h100}  // R9 unbanked
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    mode_load = 0; wr_en = 0; dbg_wr_en = 0; sps_wr_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mode_in = 0; mode_load = 0; pc_in = 32'hDEAD0000;
    rda_addr = 0; rdb_addr = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    dbg_mode = 0; dbg_addr = 0; dbg_wr_en = 0; dbg_wdata = 0;
    cur_psr = 32'hCAFE0000; sps_mode = 0; sps_wr_en = 0; sps_byte_en = 0; sps_wdata = 0;
    @(negedge clk);
    do_reset();

    chk("R11 mode after reset", {27'd0, mode_o}, 32'd19);
    sps_mode = 5'd19; #1;
    chk("R11 saved status after reset", sps_rdata, 32'h0);

    for (int k = 0; k < NVEC; k++) begin
      mode_load = VEC[k].ld; mode_in = VEC[k].md;
      wr_en = VEC[k].we; wr_addr = VEC[k].wa; wr_data = VEC[k].wd;
      tick();
      rda_addr = VEC[k].ra; #1;
      chk($sformatf("R2/R3/R4/R6/R12 vector %0d", k), rda_data, VEC[k].ex);
    end

    // debug port views (R5)
    dbg_mode = 5'd17; dbg_addr = 4'd8; #1;
    chk("R5 fiq r8 via debug", dbg_rdata, 32'hF8);
    dbg_mode = 5'd16; dbg_addr = 4'd13; #1;
    chk("R5 user r13 via debug", dbg_rdata, 32'h13);
    dbg_mode = 5'd18; dbg_addr = 4'd14; #1;
    chk("R5 irq r14 via debug", dbg_rdata, 32'hE2);
    dbg_mode = 5'd1; dbg_addr = 4'd0; #1;
    chk("R9 r0 shared via debug", dbg_rdata, 32'h100);

    // decode map (R1)
    dbg_mode = 5'd23; dbg_addr = 4'd13; dbg_wdata = 32'hAB; dbg_wr_en = 1;
    tick();
    dbg_mode = 5'd27; #1;
    chk("R1 undefined bank separate from abort", dbg_rdata, 32'h0);
    dbg_mode = 5'd23; #1;
    chk("R1 abort bank r13", dbg_rdata, 32'hAB);
    mode_load = 1; mode_in = 5'd23; tick();
    rda_addr = 4'd13; #1;
    chk("R1 code 23 selects abort", rda_data, 32'hAB);

    // entering dummy clears debug-written content (R4)
    dbg_mode = 5'd12; dbg_addr = 4'd10; dbg_wdata = 32'h3C; dbg_wr_en = 1;
    tick();
    dbg_mode = 5'd6; #1;
    chk("R4 dummy holds debug write before entry", dbg_rdata, 32'h3C);
    mode_load = 1; mode_in = 5'd6; tick();
    rda_addr = 4'd10; #1;
    chk("R4 dummy zero on entry", rda_data, 32'h0);
    mode_load = 1; mode_in = 5'd19; tick();

    // debug naming current mode (R5)
    dbg_mode = 5'd19; dbg_addr = 4'd14; dbg_wdata = 32'h55; dbg_wr_en = 1;
    tick();
    rda_addr = 4'd14; #1;
    chk("R5 debug current-mode write seen by port", rda_data, 32'h55);

    // write with mode switch lands in old bank (R10)
    wr_en = 1; wr_addr = 4'd13; wr_data = 32'h5C; mode_load = 1; mode_in = 5'd16;
    tick();
    chk("R10 mode switched", {27'd0, mode_o}, 32'd16);
    rda_addr = 4'd13; dbg_mode = 5'd19; dbg_addr = 4'd13; #1;
    chk("R10 user r13 untouched", rda_data, 32'h13);
    chk("R10 write in old supervisor bank", dbg_rdata, 32'h5C);
    mode_load = 1; mode_in = 5'd19; tick();

    // port write beats debug write (R10)
    wr_en = 1; wr_addr = 4'd1; wr_data = 32'h1;
    dbg_wr_en = 1; dbg_mode = 5'd16; dbg_addr = 4'd1; dbg_wdata = 32'h2;
    tick();
    rda_addr = 4'd1; #1;
    chk("R10 port write wins", rda_data, 32'h1);

    // r15 (R9)
    rda_addr = 4'd15; #1;
    chk("R9 r15 reads pc_in", rda_data, 32'hDEAD0000);
    wr_en = 1; wr_addr = 4'd15; wr_data = 32'h1234; tick();
    pc_in = 32'h0000BEEF; rdb_addr = 4'd15; rda_addr = 4'd0; #1;
    chk("R9 r15 write ignored", rdb_data, 32'h0000BEEF);
    chk("R9 r0 intact after r15 write", rda_data, 32'h100);

    // saved status (R7, R8)
    sps_mode = 5'd19; sps_wr_en = 1; sps_byte_en = 4'b1111; sps_wdata = 32'h11223344;
    tick(); #1;
    chk("R8 full saved status write", sps_rdata, 32'h11223344);
    sps_wr_en = 1; sps_byte_en = 4'b0010; sps_wdata = 32'hFFFFFFFF;
    tick(); #1;
    chk("R8 extension byte only", sps_rdata, 32'h1122FF44);
    sps_mode = 5'd3; sps_wr_en = 1; sps_byte_en = 4'b1000; sps_wdata = 32'hAB000000;
    tick();
    sps_mode = 5'd19; #1;
    chk("R8 flags byte via code 3", sps_rdata, 32'hAB22FF44);
    sps_mode = 5'd16; sps_wr_en = 1; sps_byte_en = 4'b1111; sps_wdata = 32'h77777777;
    tick(); #1;
    chk("R7 user read returns cur_psr", sps_rdata, 32'hCAFE0000);
    sps_mode = 5'd31; #1;
    chk("R7 system read returns cur_psr", sps_rdata, 32'hCAFE0000);
    sps_mode = 5'd23; #1;
    chk("R7 abort saved status untouched", sps_rdata, 32'h0);
    sps_mode = 5'd19; #1;
    chk("R7 supervisor unaffected by user write", sps_rdata, 32'hAB22FF44);

    // reset mid-run (R11)
    mode_load = 1; mode_in = 5'd17; tick();
    do_reset();
    chk("R11 mode back to 19", {27'd0, mode_o}, 32'd19);
    sps_mode = 5'd19; rda_addr = 4'd0; #1;
    chk("R11 saved status cleared", sps_rdata, 32'h0);
    chk("R11 registers cleared", rda_data, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule